// File: doc/BRIEF.md
# Interrupt Source Pending-Bit Controller

This block holds one pending bit per external interrupt source. Each source has a raw input wire and a 3-bit source mode. The block synchronizes every wire and produces a rectified level, which is high when the source is asserting. From that level it sets pending bits in hardware. Software sets or clears a single pending bit through a write port that names the source by its identity number (1 to the source count). A separate take port clears a pending bit when downstream delivery logic consumes the interrupt. A global flag selects message-signalled mode or direct-delivery mode.

Software writes are filtered by the source mode, the delivery mode and the live rectified level. In message-signalled mode, a level-sensitive source is pended only when its rectified level rises. A service routine can therefore write the source's identity number to the set path just before it returns. If the source is still asserting, its pending bit is set again. If it is no longer asserting, nothing happens.

Top module: `ipc_pend_ctrl`

## Requirements
- R1: During synchronous active-high reset, and on the first cycle after it, every pending bit and every synchronizer stage is zero. With all modes 0, `rect_o` is zero.
- R2: Source mode codes are: 0 inactive, 1 detached, 2 and 3 inactive, 4 rising edge, 5 falling edge, 6 level high, 7 level low. Source n uses `src_mode[3n+2:3n]` and `src_in[n]` and has identity n+1. `rect_o[n]` follows the input after two synchronizer flops. It equals the synchronized input for modes 4 and 6, its inverse for modes 5 and 7, and 0 for the other modes.
- R3: In modes 4 and 5, the pending bit is set on the third rising clock edge after the raw input makes the selected transition (low to high for 4, high to low for 5).
- R4: In direct mode (`msi_mode`=0), a level source's pending bit is set on every cycle in which its rectified level is high. In message-signalled mode, it is set only on a low-to-high change of the rectified level.
- R5: An inactive source (modes 0, 2, 3) ignores every set, clear and take request, and its pending bit reads 0 on the cycle after it is inactive.
- R6: A detached source (mode 1) ignores its input wire and applies software set and clear requests.
- R7: An edge source applies software set (`wr_set`=1) and clear (`wr_set`=0) requests directly.
- R8: In direct mode, a level source ignores both software set and software clear requests.
- R9: In message-signalled mode, a level source ignores software clear requests. A software set request on such a source takes effect only while its rectified level is high.
- R10: Write and take requests that name identity 0, or a number above the source count, change nothing.
- R11: A take request clears the named source's pending bit on the next edge. If a set (hardware or software) hits the same source in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_mode | input | 1 | 1 = message-signalled mode, 0 = direct-delivery mode |
| src_in | input | NUM_SRC | Raw asynchronous source wires |
| src_mode | input | 3*NUM_SRC | Per-source mode, 3 bits per source |
| wr_en | input | 1 | Software pending-write strobe |
| wr_set | input | 1 | 1 = set request, 0 = clear request |
| wr_id | input | ID_W | Identity number of the written source |
| tk_en | input | 1 | Delivery take strobe |
| tk_id | input | ID_W | Identity number of the taken source |
| pend_o | output | NUM_SRC | Pending bit vector |
| rect_o | output | NUM_SRC | Rectified synchronized input level |

## Verification
The assertions check single-cycle consequences on every cycle. An inactive source always reads zero. An edge source accepts a set. A detached source with no set request stays clear. A level source in direct mode rejects writes. In message-signalled mode a level source keeps its bit through a clear and rejects a set while deasserted. A take with no competing set clears the bit. Some behaviour depends on sequences over several cycles, and only the bench scenarios show it: the three-edge latency through the synchronizer, a level source being pended only once per assertion in message-signalled mode, and the set written by the service routine re-pending a source that is still asserting.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    typedef enum logic [2:0] {
        SM_OFF    = 3'd0,
        SM_DETACH = 3'd1,
        SM_RSV2   = 3'd2,
        SM_RSV3   = 3'd3,
        SM_RISE   = 3'd4,
        SM_FALL   = 3'd5,
        SM_HIGH   = 3'd6,
        SM_LOW    = 3'd7
    } smode_e;

    localparam int SM_W = 3;

    function automatic logic sm_is_off(input logic [2:0] m);
        return (m == SM_OFF) || (m == SM_RSV2) || (m == SM_RSV3);
    endfunction

    function automatic logic sm_is_edge(input logic [2:0] m);
        return (m == SM_RISE) || (m == SM_FALL);
    endfunction

    function automatic logic sm_is_level(input logic [2:0] m);
        return (m == SM_HIGH) || (m == SM_LOW);
    endfunction

    // Asserted-sense of a synchronized wire under a given mode.
    function automatic logic sm_rect(input logic [2:0] m, input logic v);
        logic r;
        case (m)
            SM_RISE, SM_HIGH: r = v;
            SM_FALL, SM_LOW:  r = ~v;
            default:          r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ipc_sync.sv
module ipc_sync #(
    parameter int NUM_SRC = 31
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] raw_i,
    output logic [NUM_SRC-1:0] cur_o,
    output logic [NUM_SRC-1:0] prev_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] s1;
        logic [NUM_SRC-1:0] s2;
        logic [NUM_SRC-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cur_o  = st_q.s2;
    assign prev_o = st_q.s3;

endmodule

// File: rtl/ipc_rectify.sv
module ipc_rectify
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 31
) (
    input  logic                    msi_mode,
    input  logic [SM_W*NUM_SRC-1:0] mode_i,
    input  logic [NUM_SRC-1:0]      cur_i,
    input  logic [NUM_SRC-1:0]      prev_i,
    output logic [NUM_SRC-1:0]      rect_o,
    output logic [NUM_SRC-1:0]      hw_set_o
);

    always_comb begin
        rect_o   = '0;
        hw_set_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            logic [2:0] m;
            logic       now_r;
            logic       old_r;
            m         = mode_i[SM_W*i +: SM_W];
            now_r     = sm_rect(m, cur_i[i]);
            old_r     = sm_rect(m, prev_i[i]);
            rect_o[i] = now_r;
            if (sm_is_edge(m)) begin
                hw_set_o[i] = now_r & ~old_r;
            end else if (sm_is_level(m)) begin
                hw_set_o[i] = msi_mode ? (now_r & ~old_r) : now_r;
            end
        end
    end

endmodule

// File: rtl/ipc_pend_core.sv
module ipc_pend_core
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int ID_W    = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    msi_mode,
    input  logic [SM_W*NUM_SRC-1:0] mode_i,
    input  logic [NUM_SRC-1:0]      rect_i,
    input  logic [NUM_SRC-1:0]      hw_set_i,
    input  logic                    wr_en,
    input  logic                    wr_set,
    input  logic [ID_W-1:0]         wr_id,
    input  logic                    tk_en,
    input  logic [ID_W-1:0]         tk_id,
    output logic [NUM_SRC-1:0]      pend_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            logic [2:0] m;
            logic       hit_w;
            logic       hit_t;
            logic       sw_set;
            logic       sw_clr;
            logic       plain;
            m      = mode_i[SM_W*i +: SM_W];
            hit_w  = wr_en && (wr_id == ID_W'(i + 1));
            hit_t  = tk_en && (tk_id == ID_W'(i + 1));
            plain  = sm_is_edge(m) || (m == SM_DETACH);
            sw_set = hit_w && wr_set &&
                     (plain || (sm_is_level(m) && msi_mode && rect_i[i]));
            sw_clr = hit_w && !wr_set && plain;
            if (sm_is_off(m)) begin
                st_d.pend[i] = 1'b0;
            end else begin
                st_d.pend[i] = (st_q.pend[i] & ~(sw_clr | hit_t)) | sw_set | hw_set_i[i];
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        logic [2:0] m_g;
        logic       wr_g;
        logic       tk_g;
        assign m_g  = mode_i[SM_W*g +: SM_W];
        assign wr_g = wr_en && (wr_id == ID_W'(g + 1));
        assign tk_g = tk_en && (tk_id == ID_W'(g + 1));

        a_r5_inactive_zero: assert property (@(posedge clk) disable iff (rst)
            sm_is_off(m_g) |=> !pend_o[g]);

        a_r7_edge_sw_set: assert property (@(posedge clk) disable iff (rst)
            (sm_is_edge(m_g) && wr_g && wr_set) |=> pend_o[g]);

        a_r6_detached_hold: assert property (@(posedge clk) disable iff (rst)
            ((m_g == SM_DETACH) && !pend_o[g] && !(wr_g && wr_set)) |=> !pend_o[g]);

        a_r8_direct_level_no_sw: assert property (@(posedge clk) disable iff (rst)
            (!msi_mode && sm_is_level(m_g) && !pend_o[g] && !hw_set_i[g] && wr_g)
            |=> !pend_o[g]);

        a_r9_msi_level_no_clr: assert property (@(posedge clk) disable iff (rst)
            (msi_mode && sm_is_level(m_g) && pend_o[g] && wr_g && !wr_set && !tk_g)
            |=> pend_o[g]);

        a_r9_msi_set_gated: assert property (@(posedge clk) disable iff (rst)
            (msi_mode && sm_is_level(m_g) && !rect_i[g] && !pend_o[g] &&
             !hw_set_i[g] && wr_g && wr_set) |=> !pend_o[g]);

        a_r11_take_clears: assert property (@(posedge clk) disable iff (rst)
            (tk_g && !hw_set_i[g] && !(wr_g && wr_set)) |=> !pend_o[g]);
    end

endmodule

// File: rtl/ipc_pend_ctrl.sv
module ipc_pend_ctrl
    import ipc_pkg::*;
#(
    parameter int  NUM_SRC = 31,
    localparam int ID_W    = $clog2(NUM_SRC + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    msi_mode,
    input  logic [NUM_SRC-1:0]      src_in,
    input  logic [SM_W*NUM_SRC-1:0] src_mode,
    input  logic                    wr_en,
    input  logic                    wr_set,
    input  logic [ID_W-1:0]         wr_id,
    input  logic                    tk_en,
    input  logic [ID_W-1:0]         tk_id,
    output logic [NUM_SRC-1:0]      pend_o,
    output logic [NUM_SRC-1:0]      rect_o
);

    logic [NUM_SRC-1:0] cur_w;
    logic [NUM_SRC-1:0] prev_w;
    logic [NUM_SRC-1:0] hw_set_w;

    ipc_sync #(.NUM_SRC(NUM_SRC)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (src_in),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    ipc_rectify #(.NUM_SRC(NUM_SRC)) u_rect (
        .msi_mode (msi_mode),
        .mode_i   (src_mode),
        .cur_i    (cur_w),
        .prev_i   (prev_w),
        .rect_o   (rect_o),
        .hw_set_o (hw_set_w)
    );

    ipc_pend_core #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .msi_mode (msi_mode),
        .mode_i   (src_mode),
        .rect_i   (rect_o),
        .hw_set_i (hw_set_w),
        .wr_en    (wr_en),
        .wr_set   (wr_set),
        .wr_id    (wr_id),
        .tk_en    (tk_en),
        .tk_id    (tk_id),
        .pend_o   (pend_o)
    );

endmodule

// File: tb/ipc_pend_ctrl_bench.sv
module ipc_pend_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int IW         = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            msi_mode = 1'b0;
    logic [N-1:0]    src_in = '0;
    logic [3*N-1:0]  src_mode = '0;
    logic            wr_en = 1'b0;
    logic            wr_set = 1'b0;
    logic [IW-1:0]   wr_id = '0;
    logic            tk_en = 1'b0;
    logic [IW-1:0]   tk_id = '0;
    logic [N-1:0]    pend_o;
    logic [N-1:0]    rect_o;

    int    n_run  = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    ipc_pend_ctrl #(.NUM_SRC(N)) u_ipc_pend_ctrl (
        .clk(clk), .rst(rst), .msi_mode(msi_mode), .src_in(src_in),
        .src_mode(src_mode), .wr_en(wr_en), .wr_set(wr_set), .wr_id(wr_id),
        .tk_en(tk_en), .tk_id(tk_id), .pend_o(pend_o), .rect_o(rect_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference model, built from the requirement text.
    bit m_s1[N];
    bit m_s2[N];
    bit m_s3[N];
    bit m_pend[N];

    function automatic bit asserted_lvl(input int mode, input bit v);
        if (mode == 4 || mode == 6) return v;
        if (mode == 5 || mode == 7) return !v;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_pend[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                int mode;
                bit now_a, old_a, hw, sw_s, sw_c, tk, idle;
                mode  = int'(src_mode[3*i +: 3]);
                now_a = asserted_lvl(mode, m_s2[i]);
                old_a = asserted_lvl(mode, m_s3[i]);
                idle  = (mode == 0 || mode == 2 || mode == 3);
                hw = 0; sw_s = 0; sw_c = 0;
                tk = tk_en && (int'(tk_id) == i + 1);
                if (mode == 4 || mode == 5) hw = now_a && !old_a;
                if (mode >= 6) hw = msi_mode ? (now_a && !old_a) : now_a;
                if (wr_en && int'(wr_id) == i + 1) begin
                    if (mode == 1 || mode == 4 || mode == 5) begin
                        sw_s = wr_set; sw_c = !wr_set;
                    end else if (mode >= 6 && msi_mode && wr_set && now_a) begin
                        sw_s = 1;
                    end
                end
                if (idle) m_pend[i] = 0;
                else if (hw || sw_s) m_pend[i] = 1;
                else if (sw_c || tk) m_pend[i] = 0;
                m_s3[i] = m_s2[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = src_in[i];
            end
        end
    end

    always @(negedge clk) begin
        logic [N-1:0] ep, er;
        for (int i = 0; i < N; i++) begin
            ep[i] = m_pend[i];
            er[i] = asserted_lvl(int'(src_mode[3*i +: 3]), m_s2[i]);
        end
        n_run++;
        if (pend_o !== ep || rect_o !== er) begin
            n_fail++;
            $display("FAIL %s model: pend=%b rect=%b expected pend=%b rect=%b",
                     cur_req, pend_o, rect_o, ep, er);
        end
    end

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit set, input int id);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_set = set; wr_id = IW'(id);
        @(posedge clk); #1;
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic take(input int id);
        @(posedge clk); #1;
        tk_en = 1'b1; tk_id = IW'(id);
        @(posedge clk); #1;
        tk_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle;
        tick(5);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        tick(3);
        @(negedge clk);
        check("R1 pend in reset", pend_o, '0);
        check("R1 rect in reset", rect_o, '0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check("R1 pend after reset", pend_o, '0);

        // modes: 1:rise 2:fall 3:high 4:low 5:detached 6:off 7:rsv2 8:rsv3
        cur_req = "R2";
        @(posedge clk); #1;
        src_mode = {3'd3, 3'd2, 3'd0, 3'd1, 3'd7, 3'd6, 3'd5, 3'd4};
        src_in   = 8'b1111_0000;
        settle();
        check("R2 rect per mode", rect_o, 8'b0000_1010);
        check("R4 direct level-low pends", pend_o, 8'b0000_1000);

        cur_req = "R3";
        src_in[0] = 1'b1;
        tick(2);
        @(negedge clk);
        check("R3 no pend before third edge", pend_o, 8'b0000_1000);
        @(negedge clk);
        check("R3 rising pends on third edge", pend_o, 8'b0000_1001);

        cur_req = "R11";
        take(1);
        check("R11 take clears edge", pend_o, 8'b0000_1000);

        cur_req = "R8";
        wr(1'b0, 4);
        check("R8 direct level ignores clear", pend_o, 8'b0000_1000);
        take(4);
        check("R11 hw set beats take", pend_o, 8'b0000_1000);
        wr(1'b1, 3);
        check("R8 direct level ignores set", pend_o, 8'b0000_1000);

        cur_req = "R5";
        wr(1'b1, 6); wr(1'b1, 7); wr(1'b1, 8);
        check("R5 inactive ignores set", pend_o, 8'b0000_1000);

        cur_req = "R6";
        wr(1'b1, 5);
        check("R6 detached sw set", pend_o, 8'b0001_1000);
        wr(1'b0, 5);
        check("R6 detached sw clear", pend_o, 8'b0000_1000);

        cur_req = "R10";
        wr(1'b1, 0); wr(1'b1, 9); wr(1'b1, 15); take(9); take(0);
        check("R10 invalid ids ignored", pend_o, 8'b0000_1000);

        cur_req = "R7";
        wr(1'b1, 2);
        check("R7 edge sw set", pend_o, 8'b0000_1010);
        wr(1'b0, 2);
        check("R7 edge sw clear", pend_o, 8'b0000_1000);

        cur_req = "R3";
        src_in[1] = 1'b1;
        settle();
        check("R3 falling mode ignores rise", pend_o, 8'b0000_1000);
        src_in[1] = 1'b0;
        settle();
        check("R3 falling edge pends", pend_o, 8'b0000_1010);
        take(2);

        cur_req = "R4";
        msi_mode = 1'b1;
        src_in[3] = 1'b1;
        settle();
        take(4);
        check("R4 msi take clears level", pend_o, 8'b0000_0000);
        src_in[2] = 1'b1;
        settle();
        check("R4 msi level rise pends", pend_o, 8'b0000_0100);
        take(3);
        settle();
        check("R4 msi held level no re-pend", pend_o, 8'b0000_0000);

        cur_req = "R9";
        wr(1'b1, 3);
        check("R9 msi set while asserted", pend_o, 8'b0000_0100);
        wr(1'b0, 3);
        check("R9 msi clear ignored", pend_o, 8'b0000_0100);
        take(3);
        src_in[2] = 1'b0;
        settle();
        wr(1'b1, 3);
        check("R9 msi set ignored when deasserted", pend_o, 8'b0000_0000);
        wr(1'b1, 4);
        check("R9 msi level-low set ignored when high", pend_o, 8'b0000_0000);
        src_in[3] = 1'b0;
        settle();
        check("R4 msi level-low assert pends", pend_o, 8'b0000_1000);
        take(4);
        wr(1'b1, 4);
        check("R9 msi re-pend still asserted", pend_o, 8'b0000_1000);

        cur_req = "R5";
        @(posedge clk); #1;
        src_mode[3*3 +: 3] = 3'd0;
        @(posedge clk); #1;
        @(negedge clk);
        check("R5 inactive reads zero", pend_o, 8'b0000_0000);

        tick(2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule